// File: doc/BRIEF.md
# Zero-Cross Digital Volume Attenuator

This block scales signed PCM samples for an eight-channel output path, arranged as four stereo pairs. Samples arrive one at a time, each with a valid strobe and a channel index. Every channel has its own 8-bit attenuation code and its own polarity-invert bit. The gain follows a log law in 0.5 dB steps, and one code is reserved for mute. The product is rounded to the nearest value and saturated back to the sample width.

New codes come in through a write strobe that carries a channel index and a code. With zero-cross gating off, a new code applies to the next sample of that channel. With gating on, the code is held pending. It applies when that channel's waveform passes through zero, which avoids audible zipper steps. A per-channel sample counter forces the pending code in if the signal never crosses zero. The scaled sample leaves two clock cycles after it entered, together with its valid strobe and channel index.

Top module: `zc_vol_atten`

## Requirements
- R1: Attenuation code 0x00 is mute. A sample of that channel leaves as exactly 0.
- R2: For a code c from 1 to 255, let a = 255 - c. The gain is m[a mod 12] / 32768 * 2^-(a div 12), where m[k] = round(32768 * 10^(-k/40)). Code 0xFF is therefore unity, and each code step changes the gain by 0.5 dB.
- R3: The scaled value is rounded to nearest, with ties toward plus infinity. The result is saturated to the signed sample width. Inverting the most negative sample at unity gain gives the most positive value.
- R4: When bit n of phase_i is 1, the output of channel n is negated; when it is 0, the output is not negated. Channel n is the channel whose index is n. Bit 0 is pair 1 left, bit 1 is pair 1 right, and so on up to bit 7, which is pair 4 right.
- R5: With zc_en_i at 0, a written code applies to every later sample of that channel. Other channels are not affected.
- R6: With zc_en_i at 1, a written code is held pending. The first later sample of that channel that is zero, or whose sign differs from the previous sample of the same channel, is scaled with the new code. Earlier samples keep the old code.
- R7: With zc_en_i at 1 and no zero crossing, the pending code is applied to the 1024th valid sample of that channel that follows the write.
- R8: out_valid_o and out_ch_o repeat sample_valid_i and sample_ch_i exactly two clock cycles later. out_o is 0 whenever out_valid_o is 0.
- R9: A sample that arrives in the same cycle as a write to its own channel is scaled with the code that was in force before that write.
- R10: After reset, every channel has code 0xFF (unity gain), no code is pending, and the outputs are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| zc_en_i | input | 1 | Zero-cross gating enable |
| phase_i | input | 8 | Per-channel polarity invert, bit n = channel n |
| wr_en_i | input | 1 | Attenuation code write strobe |
| wr_ch_i | input | 3 | Channel index of the write |
| wr_code_i | input | 8 | Attenuation code to write |
| sample_valid_i | input | 1 | Input sample strobe |
| sample_ch_i | input | 3 | Channel index of the input sample |
| sample_i | input | 24 | Signed input sample |
| out_valid_o | output | 1 | Output sample strobe |
| out_ch_o | output | 3 | Channel index of the output sample |
| out_o | output | 24 | Signed scaled output sample |

## Verification
A code write and a sample of the same channel can arrive in the same clock cycle, and the sample must still use the code that was in force before the write. The bench drives both strobes on one edge, with gating off and again with gating on. It expects the old gain on that sample and the new gain (or the pending behaviour) on the next one. A zero-crossing commit and a fresh write can also coincide, and the checker requires the new write to leave the channel pending.

// File: rtl/zva_pkg.sv
package zva_pkg;
  localparam int unsigned MANT_W  = 16;  // Q1.15 mantissa, 32768 = unity
  localparam int unsigned FRAC_W  = 15;
  localparam int unsigned SHIFT_W = 5;
  localparam int unsigned STEPS   = 12;  // 0.5 dB steps per ~6 dB octave
endpackage

// File: rtl/zva_gain_lut.sv
module zva_gain_lut
  import zva_pkg::*;
#(
  parameter int unsigned CODE_W = 8
) (
  input  logic [CODE_W-1:0]  code_i,
  output logic [MANT_W-1:0]  mant_o,
  output logic [SHIFT_W-1:0] shift_o,
  output logic               mute_o
);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;

  logic [CODE_W-1:0] atten;
  logic [CODE_W-1:0] idx;

  always_comb begin
    atten   = CODE_MAX - code_i;
    idx     = atten % CODE_W'(STEPS);
    shift_o = SHIFT_W'(atten / CODE_W'(STEPS));
    mute_o  = (code_i == '0);
    case (idx)
      8'd0:    mant_o = 16'd32768;
      8'd1:    mant_o = 16'd30935;
      8'd2:    mant_o = 16'd29205;
      8'd3:    mant_o = 16'd27571;
      8'd4:    mant_o = 16'd26029;
      8'd5:    mant_o = 16'd24573;
      8'd6:    mant_o = 16'd23198;
      8'd7:    mant_o = 16'd21900;
      8'd8:    mant_o = 16'd20675;
      8'd9:    mant_o = 16'd19519;
      8'd10:   mant_o = 16'd18427;
      default: mant_o = 16'd17396;
    endcase
  end
endmodule

// File: rtl/zva_ch_ctrl.sv
module zva_ch_ctrl #(
  parameter int unsigned CODE_W  = 8,
  parameter int unsigned TIMEOUT = 1024,
  parameter int unsigned CNT_W   = $clog2(TIMEOUT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              zc_en_i,
  input  logic              wr_i,
  input  logic [CODE_W-1:0] wr_code_i,
  input  logic              smp_v_i,
  input  logic              smp_neg_i,
  input  logic              smp_zero_i,
  output logic [CODE_W-1:0] eff_code_o,
  output logic              pend_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT - 1);

  logic [CODE_W-1:0] act_q, pcode_q;
  logic              pend_q, neg_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              zc, hit, commit;

  always_comb begin
    zc         = smp_zero_i || (smp_neg_i != neg_q);
    hit        = pend_q && (zc || cnt_q == CNT_LAST);
    commit     = hit && smp_v_i;
    eff_code_o = hit ? pcode_q : act_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= '1;
      pcode_q <= '1;
      pend_q  <= 1'b0;
      neg_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      if (smp_v_i) neg_q <= smp_neg_i;
      if (wr_i) begin  // a write overrides a same-cycle commit
        cnt_q <= '0;
        if (zc_en_i) begin
          pcode_q <= wr_code_i;
          pend_q  <= 1'b1;
        end else begin
          act_q  <= wr_code_i;
          pend_q <= 1'b0;
        end
      end else if (commit) begin
        act_q  <= pcode_q;
        pend_q <= 1'b0;
        cnt_q  <= '0;
      end else if (pend_q && smp_v_i) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign pend_o = pend_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/zva_scale.sv
module zva_scale
  import zva_pkg::*;
#(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned CH_W   = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     v_i,
  input  logic [CH_W-1:0]          ch_i,
  input  logic signed [DATA_W-1:0] smp_i,
  input  logic [MANT_W-1:0]        mant_i,
  input  logic [SHIFT_W-1:0]       shift_i,
  input  logic                     mute_i,
  input  logic                     inv_i,
  output logic                     v_o,
  output logic [CH_W-1:0]          ch_o,
  output logic signed [DATA_W-1:0] data_o
);
  localparam int unsigned PW  = DATA_W + MANT_W + 2;
  localparam int unsigned TSW = SHIFT_W + 1;
  localparam logic signed [PW-1:0] MAXV =
    signed'({{(PW-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}});
  localparam logic signed [PW-1:0] MINV = ~MAXV;

  logic signed [PW-1:0] prod, half, scaled, signd, sat;
  logic [TSW-1:0]       tot;

  always_comb begin
    tot    = TSW'(shift_i) + TSW'(FRAC_W);
    prod   = PW'(smp_i) * PW'($signed({1'b0, mant_i}));
    half   = PW'(1) <<< (tot - 1'b1);
    scaled = (prod + half) >>> tot;
    signd  = inv_i ? -scaled : scaled;
    if (signd > MAXV)      sat = MAXV;
    else if (signd < MINV) sat = MINV;
    else                   sat = signd;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_o    <= 1'b0;
      ch_o   <= '0;
      data_o <= '0;
    end else begin
      v_o    <= v_i;
      ch_o   <= v_i ? ch_i : '0;
      data_o <= (v_i && !mute_i) ? sat[DATA_W-1:0] : '0;
    end
  end
endmodule

// File: rtl/zc_vol_atten.sv
module zc_vol_atten
  import zva_pkg::*;
#(
  parameter int unsigned DATA_W  = 24,
  parameter int unsigned N_CH    = 8,
  parameter int unsigned CODE_W  = 8,
  parameter int unsigned TIMEOUT = 1024,
  localparam int unsigned CH_W   = $clog2(N_CH),
  localparam int unsigned CNT_W  = $clog2(TIMEOUT + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     zc_en_i,
  input  logic [N_CH-1:0]          phase_i,
  input  logic                     wr_en_i,
  input  logic [CH_W-1:0]          wr_ch_i,
  input  logic [CODE_W-1:0]        wr_code_i,
  input  logic                     sample_valid_i,
  input  logic [CH_W-1:0]          sample_ch_i,
  input  logic signed [DATA_W-1:0] sample_i,
  output logic                     out_valid_o,
  output logic [CH_W-1:0]          out_ch_o,
  output logic signed [DATA_W-1:0] out_o
);
  logic [CODE_W-1:0]     eff_a [N_CH];
  logic [N_CH-1:0]       pend_w;
  logic [N_CH*CNT_W-1:0] cnt_w;

  logic smp_neg, smp_zero;
  assign smp_neg  = sample_i[DATA_W-1];
  assign smp_zero = (sample_i == '0);

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    zva_ch_ctrl #(.CODE_W(CODE_W), .TIMEOUT(TIMEOUT), .CNT_W(CNT_W)) u_ctrl (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .zc_en_i    (zc_en_i),
      .wr_i       (wr_en_i && wr_ch_i == CH_W'(c)),
      .wr_code_i  (wr_code_i),
      .smp_v_i    (sample_valid_i && sample_ch_i == CH_W'(c)),
      .smp_neg_i  (smp_neg),
      .smp_zero_i (smp_zero),
      .eff_code_o (eff_a[c]),
      .pend_o     (pend_w[c]),
      .cnt_o      (cnt_w[c*CNT_W +: CNT_W])
    );
  end

  logic [MANT_W-1:0]  lut_mant;
  logic [SHIFT_W-1:0] lut_shift;
  logic               lut_mute;

  zva_gain_lut #(.CODE_W(CODE_W)) u_lut (
    .code_i  (eff_a[sample_ch_i]),
    .mant_o  (lut_mant),
    .shift_o (lut_shift),
    .mute_o  (lut_mute)
  );

  // stage 1: capture sample and decoded gain
  logic                     s1_v, s1_mute, s1_inv;
  logic [CH_W-1:0]          s1_ch;
  logic signed [DATA_W-1:0] s1_smp;
  logic [MANT_W-1:0]        s1_mant;
  logic [SHIFT_W-1:0]       s1_shift;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v     <= 1'b0;
      s1_mute  <= 1'b0;
      s1_inv   <= 1'b0;
      s1_ch    <= '0;
      s1_smp   <= '0;
      s1_mant  <= '0;
      s1_shift <= '0;
    end else begin
      s1_v <= sample_valid_i;
      if (sample_valid_i) begin
        s1_ch    <= sample_ch_i;
        s1_smp   <= sample_i;
        s1_mant  <= lut_mant;
        s1_shift <= lut_shift;
        s1_mute  <= lut_mute;
        s1_inv   <= phase_i[sample_ch_i];
      end
    end
  end

  zva_scale #(.DATA_W(DATA_W), .CH_W(CH_W)) u_scale (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .v_i     (s1_v),
    .ch_i    (s1_ch),
    .smp_i   (s1_smp),
    .mant_i  (s1_mant),
    .shift_i (s1_shift),
    .mute_i  (s1_mute),
    .inv_i   (s1_inv),
    .v_o     (out_valid_o),
    .ch_o    (out_ch_o),
    .data_o  (out_o)
  );
endmodule

// File: rtl/zva_checker.sv
module zva_checker #(
  parameter int unsigned DATA_W  = 24,
  parameter int unsigned N_CH    = 8,
  parameter int unsigned TIMEOUT = 1024,
  parameter int unsigned CH_W    = 3,
  parameter int unsigned CNT_W   = 11
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     zc_en_i,
  input logic                     wr_en_i,
  input logic [CH_W-1:0]          wr_ch_i,
  input logic                     sample_valid_i,
  input logic [CH_W-1:0]          sample_ch_i,
  input logic                     out_valid_o,
  input logic [CH_W-1:0]          out_ch_o,
  input logic signed [DATA_W-1:0] out_o,
  input logic [N_CH-1:0]          pend_i,
  input logic [N_CH*CNT_W-1:0]    cnt_i
);
  AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_i |=> ##1 out_valid_o);  // R8
  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_valid_i |=> ##1 !out_valid_o);  // R8
  AST_CH_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_i |=> ##1 (out_ch_o == $past(sample_ch_i, 2)));  // R8
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> out_o == '0);  // R8
  AST_ZC_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && zc_en_i) |=> pend_i[$past(wr_ch_i)]);  // R6
  AST_DIRECT_APPLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !zc_en_i) |=> !pend_i[$past(wr_ch_i)]);  // R5
  for (genvar c = 0; c < N_CH; c++) begin : g_cnt
    AST_TIMEOUT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_i[c*CNT_W +: CNT_W] < CNT_W'(TIMEOUT));  // R7
  end
endmodule

bind zc_vol_atten zva_checker #(
  .DATA_W(DATA_W), .N_CH(N_CH), .TIMEOUT(TIMEOUT), .CH_W(CH_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .zc_en_i        (zc_en_i),
  .wr_en_i        (wr_en_i),
  .wr_ch_i        (wr_ch_i),
  .sample_valid_i (sample_valid_i),
  .sample_ch_i    (sample_ch_i),
  .out_valid_o    (out_valid_o),
  .out_ch_o       (out_ch_o),
  .out_o          (out_o),
  .pend_i         (pend_w),
  .cnt_i          (cnt_w)
);

// File: tb/sim_zc_vol_atten.sv
module sim_zc_vol_atten;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 24;
  localparam int NV = 10;
  localparam logic signed [DW-1:0] SMAX = 24'sh7FFFFF;
  localparam logic signed [DW-1:0] SMIN = 24'sh800000;

  logic clk = 0, rst_n = 0;
  logic zc_en = 0, wr_en = 0, s_v = 0;
  logic [7:0] phase = 0, wr_code = 0;
  logic [2:0] wr_ch = 0, s_ch = 0;
  logic signed [DW-1:0] s_d = 0;
  logic o_v;
  logic [2:0] o_ch;
  logic signed [DW-1:0] o_d;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  zc_vol_atten u0 (
    .clk_i(clk), .rst_ni(rst_n), .zc_en_i(zc_en), .phase_i(phase),
    .wr_en_i(wr_en), .wr_ch_i(wr_ch), .wr_code_i(wr_code),
    .sample_valid_i(s_v), .sample_ch_i(s_ch), .sample_i(s_d),
    .out_valid_o(o_v), .out_ch_o(o_ch), .out_o(o_d));

  // {ch[3], code[8], inv[1], sample[24]}
  localparam logic [35:0] VEC [NV] = '{
    {3'd0, 8'hFF, 1'b0, 24'sd123456},
    {3'd1, 8'hF3, 1'b0, 24'sd1000},
    {3'd2, 8'hF3, 1'b0, 24'sd3},
    {3'd3, 8'hF3, 1'b0, -24'sd3},
    {3'd4, 8'hFE, 1'b0, 24'sd100000},
    {3'd5, 8'h01, 1'b0, 24'sh7FFFFF},
    {3'd6, 8'h80, 1'b1, -24'sd777777},
    {3'd7, 8'hE5, 1'b0, -24'sd54321},
    {3'd0, 8'h00, 1'b0, 24'sd99999},
    {3'd1, 8'hFF, 1'b1, 24'sh800000}
  };

  function automatic longint mant(int k);
    return longint'($rtoi(32768.0 * (10.0 ** (-k / 40.0)) + 0.5));
  endfunction

  function automatic logic signed [DW-1:0] model(longint s, int code, bit inv);
    longint p, r;
    int a, sh;
    if (code == 0) return '0;  // R1
    a  = 255 - code;
    sh = a / 12 + 15;
    p  = s * mant(a % 12);      // R2
    r  = (p + (64'sd1 <<< (sh - 1))) >>> sh;  // R3
    if (inv) r = -r;            // R4
    if (r > longint'(SMAX)) r = longint'(SMAX);
    if (r < longint'(SMIN)) r = longint'(SMIN);
    return DW'(r);
  endfunction

  task automatic check(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write(int ch, int code);
    @(negedge clk);
    wr_en = 1; wr_ch = 3'(ch); wr_code = 8'(code);
    @(negedge clk);
    wr_en = 0;
  endtask

  // drive one sample, return output two cycles later
  task automatic send(int ch, longint d, output longint res);
    @(negedge clk);
    s_v = 1; s_ch = 3'(ch); s_d = DW'(d);
    @(negedge clk);
    s_v = 0; s_d = 0;
    @(negedge clk);
    check("R8 valid", o_v, 1);
    check("R8 channel", o_ch, ch);
    res = o_d;
  endtask

  initial begin
    #(CLK_PERIOD * 250000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    longint r;
    repeat (3) @(negedge clk);
    check("R10 reset valid", o_v, 0);
    check("R10 reset data", o_d, 0);
    rst_n = 1;
    send(2, 4321, r);
    check("R10 reset unity", r, 4321);
    @(negedge clk);
    check("R8 idle zero", o_d, 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [35:0] v;
      v = VEC[i];
      phase = 8'(v[24]) << v[35:33];
      write(int'(v[35:33]), int'(v[32:25]));
      send(int'(v[35:33]), longint'($signed(v[23:0])), r);
      check("R1 R2 R3 R4 table", r, model(longint'($signed(v[23:0])), int'(v[32:25]), v[24]));
    end
    phase = 0;
    // exact values for rounding and saturation
    write(2, 8'hF3); send(2, 3, r);  check("R3 round tie up", r, 2);
    send(2, -3, r);                   check("R3 round negative tie", r, -1);
    write(1, 8'hFF); phase = 8'h02;
    send(1, longint'(SMIN), r);       check("R3 invert saturate", r, longint'(SMAX));
    phase = 8'h08;                    // R4: bit 3 = pair 2 right only
    write(3, 8'hFF); write(2, 8'hFF);
    send(3, 500, r);                  check("R4 bit3 inverts ch3", r, -500);
    send(2, 500, r);                  check("R4 ch2 untouched", r, 500);
    phase = 0;
    write(0, 8'h00); send(0, 5, r);   check("R1 mute", r, 0);
    write(0, 8'hFF); send(0, 77, r);  check("R5 immediate apply", r, 77);
    send(4, 100000, r);               check("R5 other channel kept", r, model(100000, 8'hFE, 0));

    // R9: write and sample in the same cycle, gating off
    write(5, 8'hFF);
    @(negedge clk);
    wr_en = 1; wr_ch = 5; wr_code = 8'hF3; s_v = 1; s_ch = 5; s_d = 1000;
    @(negedge clk);
    wr_en = 0; s_v = 0; s_d = 0;
    @(negedge clk);
    check("R9 old code on same cycle", o_d, 1000);
    send(5, 1000, r);                 check("R9 new code after", r, 500);

    // R6: deferral until zero crossing
    zc_en = 1;
    write(6, 8'hFF); send(6, 200, r);
    write(6, 8'hF3);
    send(6, 200, r);                  check("R6 held before crossing", r, 200);
    send(6, 400, r);                  check("R6 still held", r, 400);
    send(6, -400, r);                 check("R6 applied at crossing", r, -200);
    send(6, -400, r);                 check("R6 stays applied", r, -200);
    send(7, 10, r);
    write(7, 8'hF3);
    send(7, 0, r);                    check("R6 zero sample commits", r, 0);
    send(7, 1000, r);                 check("R6 zero then new gain", r, 500);

    // R9 with gating on: same-cycle write sees old state
    write(7, 8'hFF);
    send(7, -50, r);                  check("R9 gated commit", r, -50);
    @(negedge clk);
    wr_en = 1; wr_ch = 7; wr_code = 8'hF3; s_v = 1; s_ch = 7; s_d = 1000;
    @(negedge clk);
    wr_en = 0; s_v = 0; s_d = 0;
    @(negedge clk);
    check("R9 gated same cycle old code", o_d, 1000);
    send(7, 1000, r);                 check("R9 gated still pending", r, 1000);

    // R7: timeout on DC input
    write(6, 8'hFF); send(6, 1000, r);
    write(6, 8'hF3);
    for (int k = 1; k < 1024; k++) begin
      send(6, 1000, r);
      if (k == 1023) check("R7 held at 1023rd sample", r, 1000);
    end
    send(6, 1000, r);                 check("R7 applied at 1024th sample", r, 500);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule